// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache Controller

This block is a small direct-mapped data cache that sits between a processor and a slower line-oriented memory. The processor side issues one byte-wide access at a time. It holds a request (address, read or write, store byte) with a valid flag until the cache raises ready. The memory side moves whole lines, one line per request/acknowledge transfer, in either direction.

Each line slot keeps a valid flag, a dirty flag, an address tag and the line bytes. An access whose tag matches a valid slot is served in the cycle it is presented. Loads return the addressed byte. Stores update the byte and mark the slot dirty without touching memory. On a miss the controller stalls the processor. If the slot holds modified data, the controller first sends the old line back to memory. It then fetches the requested line, installs it clean, and completes the access from the freshly filled slot. A store that missed is therefore merged into the fetched line, and that line stays dirty.

The geometry is set by parameters. By default it is 64 bytes of storage in 8-byte lines, addressed by 48 bits.

Top module: `wb_cache`

## Requirements
- R1: The address splits into a byte offset of log2(line bytes) bits at the bottom (bits 2..0 by default), then a slot index of log2(line count) bits (bits 5..3), then a tag of the remaining upper bits (42 bits by default). Two addresses that differ only in a tag bit, even the topmost, map to the same slot and displace each other.
- R2: After synchronous reset every slot is invalid and clean. The first access to any slot misses, fetches its line, and writes nothing back.
- R3: A load that hits raises cpu_ready in the same cycle the request is presented. cpu_rdata then carries the addressed byte, and no memory transfer occurs.
- R4: A miss whose slot is invalid or clean skips the writeback. It performs exactly one line read from memory, and the access then completes with data taken from the filled line.
- R5: A miss whose slot is valid and dirty first writes the resident line to memory, then reads the new line. The line just filled is clean, so a later eviction of it writes nothing back.
- R6: A store that hits replaces only the addressed byte and marks the slot dirty. It causes no memory transfer.
- R7: A store that misses writes back a dirty victim if there is one, then fetches the line. It merges the store byte into the fetched line and leaves the slot dirty.
- R8: During a writeback or fill, cpu_ready stays low. mem_req, mem_we and mem_addr stay constant until the cycle in which mem_ack is sampled high.
- R9: mem_addr is line aligned, with offset bits zero. A writeback uses the resident tag with the current index. A fill uses the requested tag with the current index.
- R10: Only one processor request is handled at a time. A request completes in the cycle cpu_valid and cpu_ready are both high, and the processor keeps its request fields stable until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = store byte, 0 = load byte |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, meaningful while cpu_ready is high on a load |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = line writeback, 0 = line fill |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 8*LINE_BYTES | Line sent on writeback |
| mem_rdata | input | 8*LINE_BYTES | Line returned on fill, valid with mem_ack |
| mem_ack | input | 1 | Transfer finished this cycle |

## Verification
The assertions check several rules on every cycle. The processor is stalled whenever a memory transfer is open. A line transfer holds its direction and address until acknowledged. A writeback is always followed by a fill and is only issued for a valid dirty slot. A dirty flag never sits on an invalid slot, and a completed store leaves its slot dirty. Other behaviour only shows in the bench's scenarios, which compare against an independent model of memory and slot state: whether a given access hits or misses, the exact count of writebacks and fills per access, the bytes carried in a writeback line, and the merged value a later load reads back. Tag aliasing on the top tag bit and eviction of a freshly filled clean line are also scenario-level matters.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } wbc_state_e;

    // storage update commands issued by the controller
    typedef struct packed {
        logic tag_fill;   // install new tag, valid, clean; write full line
        logic set_dirty;  // byte store into resident line, mark dirty
    } wbc_upd_t;

    function automatic logic idle_state(input wbc_state_e s);
        return s == ST_IDLE;
    endfunction

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 42
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] new_tag,
    input  wbc_upd_t         upd,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);

    logic [LINES-1:0] valid_v;
    logic [LINES-1:0] dirty_v;
    logic [TAG_W-1:0] tag_v [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        logic             sel;
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        assign sel = (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (sel && upd.tag_fill) begin
                v_q <= 1'b1;
                d_q <= 1'b0;
            end else if (sel && upd.set_dirty) begin
                d_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && upd.tag_fill) begin
                t_q <= new_tag;
            end
        end

        assign valid_v[g] = v_q;
        assign dirty_v[g] = d_q;
        assign tag_v[g]   = t_q;
    end

    assign rd_valid = valid_v[idx];
    assign rd_dirty = dirty_v[idx];
    assign rd_tag   = tag_v[idx];

    // R5: a dirty flag is only ever carried by a valid slot
    a_r5_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (dirty_v & ~valid_v) == '0);

    // R2: a fill command always leaves the slot valid and clean
    a_r2_fill_clean: assert property (@(posedge clk) disable iff (rst)
        upd.tag_fill |=> (rd_valid && !rd_dirty) || $changed(idx));

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int LINES      = 8,
    parameter int IDX_W      = 3,
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = 3
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             idx,
    input  logic [OFF_W-1:0]             off,
    input  logic                         fill_en,
    input  logic [LINE_BYTES-1:0][7:0]   fill_line,
    input  logic                         byte_en,
    input  logic [7:0]                   byte_data,
    output logic [LINE_BYTES-1:0][7:0]   rd_line,
    output logic [7:0]                   rd_byte
);

    logic [LINE_BYTES-1:0][7:0] line_v [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        logic                       sel;
        logic [LINE_BYTES-1:0][7:0] l_q;

        assign sel = (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                l_q <= fill_line;
            end else if (sel && byte_en) begin
                l_q[off] <= byte_data;
            end
        end

        assign line_v[g] = l_q;
    end

    assign rd_line = line_v[idx];
    assign rd_byte = rd_line[off];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cpu_valid,
    input  logic     cpu_we,
    input  logic     hit,
    input  logic     victim_dirty,
    input  logic     mem_ack,
    output logic     cpu_ready,
    output logic     mem_req,
    output logic     mem_we,
    output wbc_upd_t upd
);

    wbc_state_e state_q;
    wbc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid && !hit) begin
                    state_d = victim_dirty ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        cpu_ready     = idle_state(state_q) && hit;
        mem_req       = (state_q == ST_EVICT) || (state_q == ST_FILL);
        mem_we        = (state_q == ST_EVICT);
        upd.tag_fill  = (state_q == ST_FILL) && mem_ack;
        upd.set_dirty = idle_state(state_q) && cpu_valid && hit && cpu_we;
    end

    // R8: an open transfer keeps its direction until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && (mem_we == $past(mem_we)));

    // R5: an acknowledged writeback is followed at once by a fill
    a_r5_fill_follows_wb: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R4: an acknowledged fill closes the memory phase
    a_r4_fill_ends: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> !mem_req);

endmodule

// File: rtl/wb_cache.sv
module wb_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int LINE_BYTES  = 8,
    parameter int CACHE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic [7:0]              cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [8*LINE_BYTES-1:0] mem_wdata,
    input  logic [8*LINE_BYTES-1:0] mem_rdata,
    input  logic                    mem_ack
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int LINES = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;

    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic             rd_valid;
    logic             rd_dirty;
    logic [TAG_W-1:0] rd_tag;
    logic             hit;
    wbc_upd_t         upd;
    logic [LINE_BYTES-1:0][7:0] rd_line;

    assign hit = rd_valid && (rd_tag == req_tag);

    wbc_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .idx      (req_idx),
        .new_tag  (req_tag),
        .upd      (upd),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag)
    );

    wbc_data_store #(
        .LINES      (LINES),
        .IDX_W      (IDX_W),
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W)
    ) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .off       (req_off),
        .fill_en   (upd.tag_fill),
        .fill_line (mem_rdata),
        .byte_en   (upd.set_dirty),
        .byte_data (cpu_wdata),
        .rd_line   (rd_line),
        .rd_byte   (cpu_rdata)
    );

    wbc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_valid    (cpu_valid),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .victim_dirty (rd_valid && rd_dirty),
        .mem_ack      (mem_ack),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .upd          (upd)
    );

    assign mem_addr  = {(mem_we ? rd_tag : req_tag), req_idx, OFF_W'(0)};
    assign mem_wdata = rd_line;

    // R8: the processor is stalled while any line transfer is open
    a_r8_stall: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    // R5: writebacks are only issued for a valid dirty slot
    a_r5_wb_dirty_only: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> rd_valid && rd_dirty);

    // R9: the transfer address holds until acknowledged
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && $stable(cpu_addr) ##1 $stable(cpu_addr) |-> $stable(mem_addr));

    // R6: a completed store leaves its slot dirty
    a_r6_store_dirty: assert property (@(posedge clk) disable iff (rst)
        cpu_valid && cpu_ready && cpu_we ##1 $stable(cpu_addr) |-> rd_dirty);

endmodule

// File: tb/wb_cache_bench.sv
`timescale 1ns/1ps
module wb_cache_bench;

    localparam int AW = 48;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0;
    logic          cpu_ready;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic [LW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #2 clk = ~clk;

    wb_cache u_wb_cache (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_ready (cpu_ready),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // four tags, including the topmost tag bit alone and all ones
    logic [41:0] tag_pool [4];
    logic [LW-1:0] mem_store [32];  // what memory holds
    logic [LW-1:0] gold      [32];  // what the processor should observe
    logic          m_valid [8];
    logic          m_dirty [8];
    int            m_tag   [8];

    int            wb_cnt, fill_cnt;
    logic [AW-1:0] exp_wb_addr, exp_fill_addr;
    logic [LW-1:0] exp_wb_data;
    int            ack_wait = 0;

    function automatic logic [AW-1:0] mk_addr(int t, int i, int o);
        return {tag_pool[t], 3'(i), 3'(o)};
    endfunction

    function automatic logic [LW-1:0] init_line(int s);
        return 64'hC3A5_5A3C_9669_0FF0 ^ (64'(s + 1) * 64'h0123_4567_89AB_CDEF);
    endfunction

    function automatic int slot_of(logic [AW-1:0] a);
        for (int t = 0; t < 4; t++)
            if (a[AW-1:6] == tag_pool[t]) return t * 8 + int'(a[5:3]);
        return -1;
    endfunction

    task automatic check(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory-side responder: random latency, one-cycle acknowledge
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst && mem_req) begin
                check(!cpu_ready, "R8 ready during transfer", 64'(cpu_ready), 0);
                check(mem_addr[2:0] == 3'd0, "R9 aligned", 64'(mem_addr[2:0]), 0);
                if (ack_wait > 0) begin
                    ack_wait--;
                end else begin
                    if (mem_we) begin
                        wb_cnt++;
                        check(mem_addr == exp_wb_addr, "R9 writeback address", 64'(mem_addr), 64'(exp_wb_addr));
                        check(mem_wdata == exp_wb_data, "R5 writeback data", mem_wdata, exp_wb_data);
                        if (slot_of(mem_addr) >= 0) mem_store[slot_of(mem_addr)] = mem_wdata;
                    end else begin
                        fill_cnt++;
                        check(mem_addr == exp_fill_addr, "R9 fill address", 64'(mem_addr), 64'(exp_fill_addr));
                        if (slot_of(mem_addr) >= 0) mem_rdata = mem_store[slot_of(mem_addr)];
                        else mem_rdata = '0;
                    end
                    mem_ack  = 1'b1;
                    ack_wait = int'($urandom % 3);
                end
            end
        end
    end

    // one processor access, checked against the bench model
    task automatic access(int t, int i, int o, bit we, logic [7:0] wd, string req);
        int  s     = t * 8 + i;
        bit  hit_e = m_valid[i] && (m_tag[i] == t);
        bit  wb_e  = !hit_e && m_valid[i] && m_dirty[i];
        int  cyc   = 0;
        logic [7:0] rd;
        exp_fill_addr = mk_addr(t, i, 0);
        if (m_valid[i]) begin
            exp_wb_addr = mk_addr(m_tag[i], i, 0);
            exp_wb_data = gold[m_tag[i] * 8 + i];
        end
        wb_cnt   = 0;
        fill_cnt = 0;
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = mk_addr(t, i, o);
        cpu_wdata = wd;
        #1;
        while (!cpu_ready && cyc < 60) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = cpu_rdata;
        check(cpu_ready, {req, " R10 completion"}, 64'(cyc), 0);
        check((cyc == 0) == hit_e, {req, " R3 hit timing"}, 64'(cyc), 64'(!hit_e));
        @(posedge clk);
        #1;
        check(wb_cnt == int'(wb_e), {req, " R5 writeback count"}, 64'(wb_cnt), 64'(wb_e));
        check(fill_cnt == int'(!hit_e), {req, " R4 fill count"}, 64'(fill_cnt), 64'(!hit_e));
        if (!we)
            check(rd == gold[s][o*8 +: 8], {req, " R3 load data"}, 64'(rd), 64'(gold[s][o*8 +: 8]));
        // model update
        if (!hit_e) begin
            m_valid[i] = 1'b1;
            m_tag[i]   = t;
            m_dirty[i] = 1'b0;
        end
        if (we) begin
            gold[s][o*8 +: 8] = wd;
            m_dirty[i] = 1'b1;
        end
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tag_pool[0] = 42'h0;
        tag_pool[1] = 42'h1;
        tag_pool[2] = 42'h200_0000_0000;
        tag_pool[3] = 42'h3FF_FFFF_FFFF;
        for (int s = 0; s < 32; s++) begin
            mem_store[s] = init_line(s);
            gold[s]      = init_line(s);
        end
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
            m_tag[i]   = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: idle after reset, and tag 0 at slot 0 must not hit
        cpu_addr  = '0;
        cpu_valid = 1'b1;
        #1;
        check(!mem_req, "R2 reset no transfer", 64'(mem_req), 0);
        check(!cpu_ready, "R2 reset invalid", 64'(cpu_ready), 0);
        cpu_valid = 1'b0;

        access(0, 0, 5, 0, 8'h00, "R2 R4 first load");
        access(0, 0, 2, 0, 8'h00, "R3 hit other byte");
        access(0, 0, 2, 1, 8'h5E, "R6 store hit");
        access(0, 0, 2, 0, 8'h00, "R6 readback");
        access(0, 0, 3, 0, 8'h00, "R6 neighbour byte");
        access(2, 0, 1, 1, 8'hA7, "R1 R7 alias top tag bit");
        access(0, 0, 2, 0, 8'h00, "R7 R1 reload merged");
        access(3, 0, 0, 0, 8'h00, "R5 clean victim");
        access(1, 4, 7, 1, 8'h11, "R7 store miss invalid");
        access(3, 4, 7, 0, 8'h00, "R5 dirty victim load");
        access(1, 4, 7, 0, 8'h00, "R5 R7 merged byte kept");
        access(2, 4, 0, 0, 8'h00, "R5 filled line clean");

        for (int n = 0; n < 500; n++) begin
            access(int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
                   bit'($urandom % 2), 8'($urandom), "R4 R5 R6 R7 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule